// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces one interrupt flag per side of a two-port shared memory. Each side owns a mailbox word at the top of the address space. The left mailbox is the word one below the highest address, and the right mailbox is the highest address. When one side writes the other side's mailbox, the other side's interrupt is raised. The receiving side drops its interrupt by reading its own mailbox. The mailbox words remain plain storage that carries a message of the user's choosing. The storage array is outside this block. The block only watches the control and address lines of both sides.

The control lines of each side are sampled on every rising clock edge. A side is active in a cycle when its chip enable is low and its busy input is high. A side whose busy input is low takes no action on either flag. Both flags are registered. Their outputs are active low.

Top module: `mbx_irq`

## Requirements
- R1: While reset is held and after it is released, with no access, both interrupt outputs are high (deasserted).
- R2: The interrupt outputs are active low: 0 means pending, 1 means idle.
- R3: The right side writing the left mailbox (address all ones except bit 0 = 0) raises the left interrupt. A write means chip enable low and read/write low (1 = read, 0 = write).
- R4: The left side writing the right mailbox (address all ones) raises the right interrupt.
- R5: The left side accessing the left mailbox with chip enable low and output enable low drops the left interrupt. The read/write line is ignored for this.
- R6: The right side accessing the right mailbox with chip enable low and output enable low drops the right interrupt. The read/write line is ignored for this.
- R7: A side whose busy input is low causes no raise and no drop.
- R8: When a raise and a drop for the same flag happen in the same cycle, the flag ends up raised.
- R9: The following leave both flags unchanged:
  - any other address;
  - chip enable high;
  - a side writing its own mailbox;
  - a mailbox access with output enable high and no write to the peer mailbox.
- R10: A flag changes on the first rising clock edge that samples the qualifying access, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_ni | input | 1 | Left chip enable, active low |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_rw_i | input | 1 | Left read/write, 1 = read, 0 = write |
| l_busy_ni | input | 1 | Left busy, low suppresses left actions |
| l_addr_i | input | ADDR_W | Left word address |
| r_ce_ni | input | 1 | Right chip enable, active low |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_rw_i | input | 1 | Right read/write, 1 = read, 0 = write |
| r_busy_ni | input | 1 | Right busy, low suppresses right actions |
| r_addr_i | input | ADDR_W | Right word address |
| l_int_no | output | 1 | Left interrupt, active low |
| r_int_no | output | 1 | Right interrupt, active low |

## Verification
The bench builds the block with ADDR_W = 3, so the two mailboxes sit at addresses 6 and 7. The control and address inputs of both sides then fit in 14 bits. That size lets a sweep visit every one of the 16384 input combinations once, in a scrambled order, with the flags carried from cycle to cycle. Each cycle checks both flags against an arithmetic model built from the requirements. Directed sequences run before the sweep and cover the following named cases:
- reset;
- the read/write line being ignored on a drop;
- busy suppression on each side;
- a simultaneous raise and drop;
- the one-edge latency.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic rw;
    logic busy_n;
  } port_ctl_t;
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter logic [ADDR_W-1:0] OWN_MBX = '0,
  parameter logic [ADDR_W-1:0] PEER_MBX = '1
) (
  input  port_ctl_t         ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              set_peer_o,
  output logic              clr_own_o
);
  logic act;
  logic hit_own;
  logic hit_peer;

  always_comb begin
    act        = !ctl_i.ce_n && ctl_i.busy_n;
    hit_own    = (addr_i == OWN_MBX);
    hit_peer   = (addr_i == PEER_MBX);
    set_peer_o = act && !ctl_i.rw && hit_peer;
    clr_own_o  = act && !ctl_i.oe_n && hit_own;
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic int_no
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign int_no = ~pend_q;

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !int_no);
  // R5
  clr_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> int_no);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(int_no));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_ni,
  input  logic              l_oe_ni,
  input  logic              l_rw_i,
  input  logic              l_busy_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              r_ce_ni,
  input  logic              r_oe_ni,
  input  logic              r_rw_i,
  input  logic              r_busy_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  output logic              l_int_no,
  output logic              r_int_no
);
  localparam int NPORT = 2;
  localparam logic [ADDR_W-1:0] L_MBX = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] R_MBX = {ADDR_W{1'b1}};

  port_ctl_t         ctl [NPORT];
  logic [ADDR_W-1:0] addr [NPORT];
  logic [NPORT-1:0]  set_peer;
  logic [NPORT-1:0]  clr_own;
  logic [NPORT-1:0]  int_n;

  always_comb begin
    ctl[0]  = '{ce_n: l_ce_ni, oe_n: l_oe_ni, rw: l_rw_i, busy_n: l_busy_ni};
    ctl[1]  = '{ce_n: r_ce_ni, oe_n: r_oe_ni, rw: r_rw_i, busy_n: r_busy_ni};
    addr[0] = l_addr_i;
    addr[1] = r_addr_i;
  end

  // Index 0 is left, 1 is right; each flag is raised by the opposite side.
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (i == 0) ? L_MBX : R_MBX;
    localparam logic [ADDR_W-1:0] PEER = (i == 0) ? R_MBX : L_MBX;

    mbx_port_dec #(
      .ADDR_W  (ADDR_W),
      .OWN_MBX (OWN),
      .PEER_MBX(PEER)
    ) u_dec (
      .ctl_i     (ctl[i]),
      .addr_i    (addr[i]),
      .set_peer_o(set_peer[i]),
      .clr_own_o (clr_own[i])
    );

    mbx_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_peer[NPORT-1-i]),
      .clr_i (clr_own[i]),
      .int_no(int_n[i])
    );
  end

  assign l_int_no = int_n[0];
  assign r_int_no = int_n[1];

  // R3
  set_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_ce_ni && !r_rw_i && r_busy_ni && r_addr_i == L_MBX) |=> !l_int_no);
  // R4
  set_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_ce_ni && !l_rw_i && l_busy_ni && l_addr_i == R_MBX) |=> !r_int_no);
  // R6
  clr_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_ce_ni && !r_oe_ni && r_busy_ni && r_addr_i == R_MBX &&
     !(!l_ce_ni && !l_rw_i && l_busy_ni && l_addr_i == R_MBX)) |=> r_int_no);
  // R7
  busy_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_busy_ni && !r_busy_ni) |=> ($stable(l_int_no) && $stable(r_int_no)));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_ce_ni && r_ce_ni) |=> ($stable(l_int_no) && $stable(r_int_no)));
endmodule

// File: tb/tb_mbx_irq.sv
`timescale 1ns/1ps
module tb_mbx_irq;
  localparam int AW = 3;
  localparam logic [AW-1:0] LM = 3'd6;
  localparam logic [AW-1:0] RM = 3'd7;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic l_ce_ni = 1'b1, l_oe_ni = 1'b1, l_rw_i = 1'b1, l_busy_ni = 1'b1;
  logic r_ce_ni = 1'b1, r_oe_ni = 1'b1, r_rw_i = 1'b1, r_busy_ni = 1'b1;
  logic [AW-1:0] l_addr_i = '0, r_addr_i = '0;
  logic l_int_no, r_int_no;

  int total = 0;
  int bad = 0;
  bit exp_l = 1'b0;
  bit exp_r = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mbx_irq #(.ADDR_W(AW)) dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic drv(input logic [6:0] lv, input logic [6:0] rv);
    // field order: addr[6:4], ce_n, oe_n, rw, busy_n
    @(negedge clk_i);
    {l_addr_i, l_ce_ni, l_oe_ni, l_rw_i, l_busy_ni} = lv;
    {r_addr_i, r_ce_ni, r_oe_ni, r_rw_i, r_busy_ni} = rv;
  endtask

  task automatic step(input logic [6:0] lv, input logic [6:0] rv);
    drv(lv, rv);
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [6:0] pv(input logic [AW-1:0] a, input bit ce_n,
                                    input bit oe_n, input bit rw, input bit busy_n);
    return {a, ce_n, oe_n, rw, busy_n};
  endfunction

  localparam logic [6:0] IDLE = {3'd0, 4'b1111};

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    chk("R1 reset left", l_int_no, 1'b1);
    chk("R1 reset right", r_int_no, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(IDLE, IDLE);
    chk("R1 after reset left", l_int_no, 1'b1);
    chk("R1 after reset right", r_int_no, 1'b1);

    // Right writes the left mailbox; before the edge nothing moves.
    drv(IDLE, pv(LM, 0, 1, 0, 1));
    #1;
    chk("R10 no change before edge", l_int_no, 1'b1);
    @(posedge clk_i);
    #1;
    chk("R3 left raised", l_int_no, 1'b0);
    chk("R2 active low pending", l_int_no, 1'b0);
    chk("R9 right untouched", r_int_no, 1'b1);

    step(pv(LM, 0, 1, 0, 1), IDLE);
    chk("R9 own-mailbox write no raise", r_int_no, 1'b1);
    chk("R9 own-mailbox write oe high no drop", l_int_no, 1'b0);
    step(pv(LM, 1, 0, 1, 1), IDLE);
    chk("R9 ce high no drop", l_int_no, 1'b0);
    step(pv(3'd2, 0, 0, 1, 1), IDLE);
    chk("R9 other address no drop", l_int_no, 1'b0);
    step(pv(LM, 0, 0, 0, 1), IDLE);
    chk("R5 drop with rw low", l_int_no, 1'b1);

    step(pv(RM, 0, 1, 0, 1), IDLE);
    chk("R4 right raised", r_int_no, 1'b0);
    step(IDLE, pv(RM, 0, 0, 1, 0));
    chk("R7 busy right blocks drop", r_int_no, 1'b0);
    step(IDLE, pv(RM, 0, 0, 1, 1));
    chk("R6 right dropped", r_int_no, 1'b1);
    step(pv(RM, 0, 1, 0, 0), IDLE);
    chk("R7 busy left blocks raise", r_int_no, 1'b1);
    step(pv(RM, 0, 1, 0, 1), pv(RM, 0, 0, 1, 1));
    chk("R8 raise wins right", r_int_no, 1'b0);
    step(pv(LM, 0, 0, 1, 1), pv(LM, 0, 1, 0, 1));
    chk("R8 raise wins left", l_int_no, 1'b0);
    step(pv(LM, 0, 0, 1, 1), pv(RM, 0, 0, 1, 1));
    chk("R5 left dropped", l_int_no, 1'b1);
    chk("R6 right dropped again", r_int_no, 1'b1);

    // Exhaustive scrambled sweep over all 2^14 input combinations.
    exp_l = 1'b0;
    exp_r = 1'b0;
    for (int i = 0; i < 16384; i++) begin
      logic [13:0] v;
      logic [6:0] lv, rv;
      bit lw, rw, lr, rr, ls, rs, lc, rc;
      v  = 14'((i * 4093 + 7) & 16383);
      lv = v[13:7];
      rv = v[6:0];
      step(lv, rv);
      lw = !lv[3] && !lv[1] && lv[0];
      rw = !rv[3] && !rv[1] && rv[0];
      lr = !lv[3] && !lv[2] && lv[0];
      rr = !rv[3] && !rv[2] && rv[0];
      ls = rw && rv[6:4] == LM;
      rs = lw && lv[6:4] == RM;
      lc = lr && lv[6:4] == LM;
      rc = rr && rv[6:4] == RM;
      if (ls) exp_l = 1'b1; else if (lc) exp_l = 1'b0;
      if (rs) exp_r = 1'b1; else if (rc) exp_r = 1'b0;
      chk("R9 sweep left", l_int_no, !exp_l);
      chk("R9 sweep right", r_int_no, !exp_r);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule